// File: doc/BRIEF.md
# Fast-Clock Glitch Pulse Generator

This block drives the select line of an external analog supply switch. While the line is high the target runs from its normal supply. While it is low the switch routes the glitch voltage to the target. The block produces one low pulse of a programmed length each time a slower controller raises an arm level. The block runs on a clock four times faster than that controller, so the pulse width can be set in steps a quarter of a system cycle long.

The arm level and the width value come from the slow domain. Each passes through a two-flop synchronizer before the block uses it. The width is captured only at the rising edge of the synchronized arm. When the pulse is over, the block raises a done level and holds it until the arm is seen low again. This release wait is what stops a short pulse from firing a second time while the slow side still holds arm high. A width of zero fires no pulse, but the arm/done exchange still runs to completion.

Top module: `glitch_pulse_gen`

## Requirements
- R1: After reset, and whenever no pulse is running, supply_sel_n_o is 1 (normal supply) and done_o is 0.
- R2: A pulse begins (supply_sel_n_o goes to 0) on the third rising edge of clk_fast after arm_i rises: two synchronizer edges, then one output register edge.
- R3: supply_sel_n_o stays 0 for exactly W clk_fast cycles, where W is the unsigned value of width_i. The largest value, 2^WIDTH_BITS-1, is included.
- R4: The width is captured once, at the rising edge of the synchronized arm. A change to width_i after arm_i has risen does not alter the running pulse.
- R5: done_o goes to 1 on the same edge where supply_sel_n_o returns to 1. It stays 1 for as long as the synchronized arm is high, and is never 1 while supply_sel_n_o is 0.
- R6: While arm_i stays high after a pulse, no second pulse is produced, even for W=1.
- R7: After arm_i falls, done_o clears on the third clk_fast edge. A later rise of arm_i then starts a new pulse.
- R8: A width of 0 produces no low cycle. done_o rises on the third edge after arm_i rises.
- R9: If arm_i falls while a pulse is running, the pulse still lasts W cycles. done_o is then 1 for exactly one cycle.
- R10: When rst is sampled high, then on that edge supply_sel_n_o becomes 1 and done_o becomes 0, which ends any pulse that was running. The block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, four times the controller clock |
| rst | input | 1 | Synchronous active-high reset, fast domain |
| arm_i | input | 1 | Arm level from the slow domain (asynchronous) |
| width_i | input | WIDTH_BITS | Pulse width in fast cycles, held steady while arming |
| supply_sel_n_o | output | 1 | Supply select: 1 = normal, 0 = glitch voltage |
| done_o | output | 1 | Pulse finished, held until arm is seen low |

## Verification
All timing is counted in clk_fast edges from the falling clock edge at which the bench changes arm_i. The select line is due low after edge 3 and high again after edge W+3. done_o is due after edge W+3, or after edge 3 when W is zero. done_o clears after the third edge that follows the fall of arm_i. The bench drives inputs and samples outputs only on falling edges. At each one it compares both outputs with bench functions of the edge index and the width, so every check falls on a cycle whose value has already settled.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    localparam int GP_WIDTH_BITS  = 8;
    localparam int GP_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2
    } glitch_state_e;

    typedef struct packed {
        logic sel_n;
        logic done;
    } glitch_out_t;

    localparam glitch_out_t GP_OUT_IDLE = '{sel_n: 1'b1, done: 1'b0};

endpackage

// File: rtl/glitch_sync.sv
module glitch_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("glitch_sync needs at least two stages");
    end
endmodule

// File: rtl/glitch_pulse_fsm.sv
module glitch_pulse_fsm
    import glitch_pkg::*;
#(
    parameter int WIDTH_BITS = GP_WIDTH_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm_s,
    input  logic [WIDTH_BITS-1:0] width_s,
    output glitch_out_t           out_o
);
    glitch_state_e         state_q;
    logic [WIDTH_BITS-1:0] cnt_q;
    logic                  arm_q;
    glitch_out_t           out_q;
    logic                  arm_rise;

    assign arm_rise = arm_s & ~arm_q;
    assign out_o    = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            arm_q   <= 1'b0;
            out_q   <= GP_OUT_IDLE;
        end else begin
            arm_q <= arm_s;
            unique case (state_q)
                ST_IDLE: begin
                    if (arm_rise) begin
                        if (width_s == '0) begin
                            state_q    <= ST_WAIT;
                            out_q.done <= 1'b1;
                        end else begin
                            state_q     <= ST_PULSE;
                            cnt_q       <= width_s;
                            out_q.sel_n <= 1'b0;
                        end
                    end
                end
                ST_PULSE: begin
                    if (cnt_q == WIDTH_BITS'(1)) begin
                        state_q     <= ST_WAIT;
                        out_q.sel_n <= 1'b1;
                        out_q.done  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - WIDTH_BITS'(1);
                    end
                end
                ST_WAIT: begin
                    if (!arm_s) begin
                        state_q    <= ST_IDLE;
                        out_q.done <= 1'b0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    out_q   <= GP_OUT_IDLE;
                end
            endcase
        end
    end

    // Checker state: length of the current low phase and the width it started with
    logic [WIDTH_BITS-1:0] chk_low_cnt;
    logic [WIDTH_BITS-1:0] chk_w_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_low_cnt <= '0;
            chk_w_lat   <= '0;
        end else begin
            if (!out_q.sel_n) chk_low_cnt <= chk_low_cnt + WIDTH_BITS'(1);
            else              chk_low_cnt <= '0;
            if (state_q == ST_IDLE && arm_rise) chk_w_lat <= width_s;
        end
    end

    p_width_exact_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_q.sel_n) && !$past(rst)) |-> (chk_low_cnt == chk_w_lat));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && arm_rise && width_s != '0) |=> !out_q.sel_n);

    p_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
        out_q.done |-> out_q.sel_n);

    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_q.done && arm_s) |=> out_q.done);

    p_end_done_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_q.sel_n) && !$past(rst)) |-> out_q.done);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(out_q.done) |-> !$past(arm_s));

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (out_q.sel_n && !out_q.done));
endmodule

// File: rtl/glitch_pulse_gen.sv
module glitch_pulse_gen
    import glitch_pkg::*;
#(
    parameter int WIDTH_BITS  = GP_WIDTH_BITS,
    parameter int SYNC_STAGES = GP_SYNC_STAGES
) (
    input  logic                  clk_fast,
    input  logic                  rst,
    input  logic                  arm_i,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic                  supply_sel_n_o,
    output logic                  done_o
);
    logic                  arm_s;
    logic [WIDTH_BITS-1:0] width_s;
    glitch_out_t           fsm_out;

    glitch_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_arm (
        .clk (clk_fast),
        .rst (rst),
        .d_i (arm_i),
        .q_o (arm_s)
    );

    glitch_sync #(.W(WIDTH_BITS), .STAGES(SYNC_STAGES)) u_sync_width (
        .clk (clk_fast),
        .rst (rst),
        .d_i (width_i),
        .q_o (width_s)
    );

    glitch_pulse_fsm #(.WIDTH_BITS(WIDTH_BITS)) u_fsm (
        .clk     (clk_fast),
        .rst     (rst),
        .arm_s   (arm_s),
        .width_s (width_s),
        .out_o   (fsm_out)
    );

    assign supply_sel_n_o = fsm_out.sel_n;
    assign done_o         = fsm_out.done;

    p_idle_r1: assert property (@(posedge clk_fast) disable iff (rst)
        (!arm_s && !$past(arm_s) && supply_sel_n_o) |=> supply_sel_n_o);
endmodule

// File: tb/glitch_pulse_gen_bench.sv
module glitch_pulse_gen_bench;
    localparam int WB   = 8;
    localparam int WMAX = (1 << WB) - 1;

    logic          clk_fast = 1'b0;
    logic          rst      = 1'b1;
    logic          arm_i    = 1'b0;
    logic [WB-1:0] width_i  = '0;
    logic          supply_sel_n_o;
    logic          done_o;

    int checks   = 0;
    int failures = 0;

    always #4 clk_fast = ~clk_fast;

    glitch_pulse_gen #(.WIDTH_BITS(WB)) u_glitch_pulse_gen (
        .clk_fast       (clk_fast),
        .rst            (rst),
        .arm_i          (arm_i),
        .width_i        (width_i),
        .supply_sel_n_o (supply_sel_n_o),
        .done_o         (done_o)
    );

    function automatic bit exp_sel(int n, int w);
        return !(w > 0 && n >= 3 && n <= w + 2);
    endfunction

    function automatic bit exp_done(int n, int w);
        return (w == 0) ? (n >= 3) : (n >= w + 3);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk_fast);
        @(negedge clk_fast);
    endtask

    // Arm with width w and hold arm for 'hold' edges, then release it.
    // perturb: change width_i after the first edge (R4).
    task automatic run_pulse(int w, int hold, bit perturb, string req);
        width_i = WB'(w);
        arm_i   = 1'b1;
        for (int n = 1; n <= hold; n++) begin
            step();
            if (perturb && n == 1) width_i = ~WB'(w);
            chk(req, "sel", supply_sel_n_o, exp_sel(n, w));
            chk(req, "done", done_o, exp_done(n, w));
        end
        arm_i = 1'b0;
        for (int m = 1; m <= 4; m++) begin
            step();
            chk("R7", "sel", supply_sel_n_o, 1);
            chk("R7", "done", done_o, (m <= 2) ? 1 : 0);
        end
    endtask

    initial begin : main
        int w;
        void'($urandom(32'd20240517));
        repeat (3) step();
        chk("R1", "reset sel", supply_sel_n_o, 1);
        chk("R1", "reset done", done_o, 0);
        rst = 1'b0;
        repeat (4) step();
        chk("R1", "idle sel", supply_sel_n_o, 1);
        chk("R1", "idle done", done_o, 0);

        run_pulse(1, 6, 1'b0, "R2");
        run_pulse(2, 8, 1'b0, "R3");
        run_pulse(0, 6, 1'b0, "R8");
        run_pulse(WMAX, WMAX + 5, 1'b0, "R3");
        run_pulse(1, 40, 1'b0, "R6");
        run_pulse(9, 20, 1'b1, "R4");
        run_pulse(100, 110, 1'b1, "R4");

        for (int i = 0; i < 30; i++) begin
            w = int'($urandom_range(0, 40));
            run_pulse(w, w + 3 + int'($urandom_range(0, 8)), i[0], "R5");
        end

        // R9: arm falls after one edge while a 12-cycle pulse runs
        width_i = WB'(12);
        arm_i   = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            step();
            if (n == 1) arm_i = 1'b0;
            chk("R9", "sel", supply_sel_n_o, exp_sel(n, 12));
            chk("R9", "done", done_o, (n == 15) ? 1 : 0);
        end

        // R10: reset in the middle of a pulse
        width_i = WB'(20);
        arm_i   = 1'b1;
        repeat (6) step();
        chk("R10", "pulse running", supply_sel_n_o, 0);
        rst   = 1'b1;
        arm_i = 1'b0;
        step();
        chk("R10", "sel after reset", supply_sel_n_o, 1);
        chk("R10", "done after reset", done_o, 0);
        step();
        rst = 1'b0;
        repeat (3) step();
        chk("R10", "idle sel", supply_sel_n_o, 1);
        run_pulse(5, 10, 1'b0, "R10");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule